// File: doc/BRIEF.md
# Arbitrated Stream Hub Interconnect

This block joins one host-side stream port to a set of peripheral stream ports (sixteen by default) with two independent one-way channels. Each channel uses valid/ready/data/last stream signalling with 32-bit words. Neither channel has a register on its data path, so a beat crosses the hub in the same cycle it is offered. The only state in the block is the upstream arbiter's.

On the downstream (host-to-peripheral) channel, a 4-bit destination field is decoded to pick one peripheral. Only that peripheral sees the host's valid, and only its ready goes back to the host. The data word and last flag go to every peripheral. On the upstream (peripheral-to-host) channel, each peripheral's valid counts as a request. A round-robin arbiter, built as a two-state machine, picks one requester and keeps it until the packet ends.

Every word carries an 8-bit source/target identity (cluster and core numbers) in bits 31:24 and a 24-bit payload below it. The hub passes all 32 bits unchanged. The highest port index is normally wired to the link toward the next hub level. That port is switched exactly like any other port.

The arbiter has two states and four transitions:
- **ARB_OPEN**: no packet is in progress. The grant goes, in the same cycle, to the first requester found by searching from the pointer upward and wrapping around.
- **ARB_HELD**: a packet is in progress. The grant stays with the recorded owner.
- **OPEN→HELD (lock)**: taken when a requester is granted and its beat does not complete with last set.
- **OPEN→OPEN (single-beat)**: taken when the granted beat completes with last set in that same cycle.
- **HELD→OPEN (release)**: taken when the owner's beat completes with last set.
- **HELD→HELD (hold)**: taken in every other cycle.

Top module: `stream_hub`

## Requirements
- R1: `pd_valid[i]` equals `dn_valid` when `dn_dest` equals i (4-bit unsigned port number), and is 0 otherwise. This holds in the same cycle, so at most one bit of `pd_valid` is ever set.
- R2: `dn_ready` equals `pd_ready` of the port addressed by `dn_dest`, in the same cycle.
- R3: `pd_data` and `pd_last` equal `dn_data` and `dn_last` on every cycle, for all ports. All 32 bits are passed unmodified, including the identity field in bits 31:24.
- R4: If no peripheral asserts `pu_valid` while the arbiter is open, then `hu_valid` is 0, all of `pu_ready` is 0, and the round-robin pointer keeps its value.
- R5: The pointer is 0 after reset. An open arbiter grants the first requester at or above the pointer, wrapping from the top port to port 0. When a packet ends, the pointer becomes the granted port plus one, modulo the port count.
- R6: A grant is kept through non-last beats, through cycles where `hu_ready` is 0, and through cycles where the owner drops `pu_valid`. It is released only after a beat with `pu_last`=1 that completes its handshake (`pu_valid` and `hu_ready` both 1).
- R7: `pu_ready` is 0 for every port that does not hold the grant. The granted port's `pu_ready` equals `hu_ready`.
- R8: `hu_valid`, `hu_data` and `hu_last` follow the granted port's `pu_valid`, data word and `pu_last` in the same cycle.
- R9: When every port requests continuously with single-beat packets, the grants go to consecutive ports in order. As a result, no requesting port waits more than NUM_PORTS-1 packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dn_valid | input | 1 | Host downstream beat valid |
| dn_ready | output | 1 | Ready of the addressed peripheral |
| dn_data | input | 32 | Host downstream word |
| dn_last | input | 1 | Host downstream end of packet |
| dn_dest | input | 4 | Destination port number |
| pd_valid | output | 16 | Per-peripheral downstream valid |
| pd_ready | input | 16 | Per-peripheral downstream ready |
| pd_data | output | 32 | Broadcast downstream word |
| pd_last | output | 1 | Broadcast downstream end of packet |
| pu_valid | input | 16 | Per-peripheral upstream valid (request) |
| pu_ready | output | 16 | Per-peripheral upstream ready |
| pu_data | input | 512 | Upstream words, port i in bits 32*i+31:32*i |
| pu_last | input | 16 | Per-peripheral upstream end of packet |
| hu_valid | output | 1 | Upstream valid to host |
| hu_ready | input | 1 | Host upstream ready |
| hu_data | output | 32 | Upstream word to host |
| hu_last | output | 1 | Upstream end of packet to host |

## Verification
All downstream results and the current upstream grant are combinational, so they are due in the cycle the stimulus is applied. The bench drives inputs at the falling edge and samples 1 ns later, before the next rising edge. Arbiter state (lock, release and pointer moves) takes effect at the first rising edge after the completing handshake. Each expected next grant is therefore checked only after exactly one further rising edge, and the expected port order is worked out from the pointer rule.

// File: rtl/hub_pkg.sv
package hub_pkg;
    typedef enum logic [0:0] {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/hub_route.sv
module hub_route #(
    parameter int NUM_PORTS = 16,
    parameter int DEST_W    = 4
) (
    input  logic                 dn_valid,
    input  logic [DEST_W-1:0]    dn_dest,
    input  logic [NUM_PORTS-1:0] pd_ready,
    output logic [NUM_PORTS-1:0] pd_valid,
    output logic                 dn_ready
);
    always_comb begin
        pd_valid = '0;
        dn_ready = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (dn_dest == DEST_W'(i)) begin
                pd_valid[i] = dn_valid;
                dn_ready    = pd_ready[i];
            end
        end
    end
endmodule

// File: rtl/hub_rr_arbiter.sv
module hub_rr_arbiter
    import hub_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int IDX_W    = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req,
    input  logic [NUM_PORTS-1:0] last,
    input  logic                 out_ready,
    output logic                 gnt_act,
    output logic [IDX_W-1:0]     gnt_idx
);
    arb_state_e       state, state_n;
    logic [IDX_W-1:0] owner, owner_n;
    logic [IDX_W-1:0] ptr, ptr_n;
    logic [IDX_W-1:0] pick_idx;
    logic             found;
    logic             done;

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a, input int b);
        int s;
        s = int'(a) + b;
        if (s >= NUM_PORTS) s = s - NUM_PORTS;
        return IDX_W'(s);
    endfunction

    // search from the pointer upward, wrapping
    always_comb begin
        found    = 1'b0;
        pick_idx = ptr;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (!found && req[wrap_add(ptr, k)]) begin
                found    = 1'b1;
                pick_idx = wrap_add(ptr, k);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ARB_OPEN: begin
                gnt_act = found;
                gnt_idx = pick_idx;
            end
            ARB_HELD: begin
                gnt_act = 1'b1;
                gnt_idx = owner;
            end
        endcase
        done = gnt_act && req[gnt_idx] && out_ready && last[gnt_idx];
    end

    // next state
    always_comb begin
        state_n = state;
        owner_n = owner;
        ptr_n   = ptr;
        if (done) begin
            state_n = ARB_OPEN;
            ptr_n   = wrap_add(gnt_idx, 1);
        end else if (state == ARB_OPEN && gnt_act) begin
            state_n = ARB_HELD;
            owner_n = gnt_idx;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_OPEN;
            owner <= '0;
            ptr   <= '0;
        end else begin
            state <= state_n;
            owner <= owner_n;
            ptr   <= ptr_n;
        end
    end

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_act && !done) |=> (gnt_act && gnt_idx == $past(gnt_idx)));

    // R4
    idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_OPEN && req == '0) |=> $stable(ptr));

    // R4
    idle_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_OPEN && req == '0) |-> !gnt_act);

    // R5
    ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ARB_OPEN && ptr != $past(gnt_idx)));
endmodule

// File: rtl/hub_up_mux.sv
module hub_up_mux #(
    parameter int NUM_PORTS = 16,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PORTS)
) (
    input  logic                        gnt_act,
    input  logic [IDX_W-1:0]            gnt_idx,
    input  logic [NUM_PORTS-1:0]        pu_valid,
    input  logic [NUM_PORTS*DATA_W-1:0] pu_data,
    input  logic [NUM_PORTS-1:0]        pu_last,
    input  logic                        hu_ready,
    output logic [NUM_PORTS-1:0]        pu_ready,
    output logic                        hu_valid,
    output logic [DATA_W-1:0]           hu_data,
    output logic                        hu_last
);
    always_comb begin
        hu_valid = gnt_act && pu_valid[gnt_idx];
        hu_data  = pu_data[int'(gnt_idx)*DATA_W +: DATA_W];
        hu_last  = pu_last[gnt_idx];
        pu_ready = '0;
        if (gnt_act) pu_ready[gnt_idx] = hu_ready;
    end
endmodule

// File: rtl/stream_hub.sv
module stream_hub #(
    parameter int NUM_PORTS = 16,
    parameter int DATA_W    = 32,
    parameter int DEST_W    = 4,
    localparam int IDX_W    = $clog2(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dn_valid,
    output logic                        dn_ready,
    input  logic [DATA_W-1:0]           dn_data,
    input  logic                        dn_last,
    input  logic [DEST_W-1:0]           dn_dest,
    output logic [NUM_PORTS-1:0]        pd_valid,
    input  logic [NUM_PORTS-1:0]        pd_ready,
    output logic [DATA_W-1:0]           pd_data,
    output logic                        pd_last,
    input  logic [NUM_PORTS-1:0]        pu_valid,
    output logic [NUM_PORTS-1:0]        pu_ready,
    input  logic [NUM_PORTS*DATA_W-1:0] pu_data,
    input  logic [NUM_PORTS-1:0]        pu_last,
    output logic                        hu_valid,
    input  logic                        hu_ready,
    output logic [DATA_W-1:0]           hu_data,
    output logic                        hu_last
);
    logic             gnt_act;
    logic [IDX_W-1:0] gnt_idx;

    // downstream: decoded valid, broadcast payload
    hub_route #(.NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W)) u_route (
        .dn_valid (dn_valid),
        .dn_dest  (dn_dest),
        .pd_ready (pd_ready),
        .pd_valid (pd_valid),
        .dn_ready (dn_ready)
    );
    assign pd_data = dn_data;
    assign pd_last = dn_last;

    // upstream: arbiter plus steering mux
    hub_rr_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pu_valid),
        .last      (pu_last),
        .out_ready (hu_ready),
        .gnt_act   (gnt_act),
        .gnt_idx   (gnt_idx)
    );

    hub_up_mux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_mux (
        .gnt_act  (gnt_act),
        .gnt_idx  (gnt_idx),
        .pu_valid (pu_valid),
        .pu_data  (pu_data),
        .pu_last  (pu_last),
        .hu_ready (hu_ready),
        .pu_ready (pu_ready),
        .hu_valid (hu_valid),
        .hu_data  (hu_data),
        .hu_last  (hu_last)
    );

    // R1
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pd_valid));

    // R1
    route_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid != '0) |-> dn_valid);

    // R2
    dn_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) |-> ((pd_valid & pd_ready) != '0));

    // R7
    up_ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pu_ready));

    // R8
    up_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hu_valid |-> (pu_valid != '0));
endmodule

// File: tb/stream_hub_tb.sv
module stream_hub_tb;
    localparam int N = 16;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dn_valid = 1'b0, dn_last = 1'b0;
    logic [W-1:0]  dn_data = '0;
    logic [3:0]    dn_dest = '0;
    logic          dn_ready;
    logic [N-1:0]  pd_valid;
    logic [N-1:0]  pd_ready = '0;
    logic [W-1:0]  pd_data;
    logic          pd_last;
    logic [N-1:0]  pu_valid = '0, pu_last = '0;
    logic [N-1:0]  pu_ready;
    logic [N*W-1:0] pu_data;
    logic          hu_valid, hu_last;
    logic          hu_ready = 1'b0;
    logic [W-1:0]  hu_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    stream_hub u_dut (.*);

    always #5 clk = ~clk;

    function automatic logic [W-1:0] word_of(int p);
        return {8'(8'h10 + p), 24'(p * 24'h010101)};
    endfunction

    initial for (int p = 0; p < N; p++) pu_data[p*W +: W] = word_of(p);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // granted port p is on the upstream channel this cycle
    task automatic chk_grant(string req, int p);
        #1;
        chk(req, "hu_valid", 64'(hu_valid), 64'(pu_valid[p]));
        chk(req, "hu_data", 64'(hu_data), 64'(word_of(p)));
        chk("R7", "pu_ready", 64'(pu_ready), hu_ready ? 64'(1) << p : 64'd0);
    endtask

    // downstream table: dest, valid, ready mask, data, last, exp valid mask, exp ready
    localparam int NV = 6;
    localparam logic [3:0]  T_DEST [NV] = '{4'd0, 4'd15, 4'd7, 4'd7, 4'd9, 4'd4};
    localparam logic        T_VLD  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [15:0] T_RDY  [NV] = '{16'hFFFF, 16'h7FFF, 16'h0080, 16'hFFFF, 16'hFDFF, 16'h0010};
    localparam logic [31:0] T_DATA [NV] = '{32'hA1000001, 32'hB2000002, 32'hC3ABCDEF,
                                            32'h11111111, 32'h22000009, 32'hFF00FFFF};
    localparam logic        T_LAST [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [15:0] T_EXPV [NV] = '{16'h0001, 16'h8000, 16'h0080, 16'h0000, 16'h0200, 16'h0010};
    localparam logic        T_EXPR [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        #1;
        // reset state (R4, R1)
        chk("R4", "reset hu_valid", 64'(hu_valid), 0);
        chk("R4", "reset pu_ready", 64'(pu_ready), 0);
        chk("R1", "reset pd_valid", 64'(pd_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // downstream vectors: R1 R2 R3
        for (int v = 0; v < NV; v++) begin
            dn_dest = T_DEST[v]; dn_valid = T_VLD[v]; pd_ready = T_RDY[v];
            dn_data = T_DATA[v]; dn_last = T_LAST[v];
            #1;
            chk("R1", "pd_valid", 64'(pd_valid), 64'(T_EXPV[v]));
            chk("R2", "dn_ready", 64'(dn_ready), 64'(T_EXPR[v]));
            chk("R3", "pd_data", 64'(pd_data), 64'(T_DATA[v]));
            chk("R3", "pd_last", 64'(pd_last), 64'(T_LAST[v]));
            step();
        end
        dn_valid = 1'b0;

        // R4: no requests, pointer stays 0
        hu_ready = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk("R4", "idle hu_valid", 64'(hu_valid), 0);
            chk("R4", "idle pu_ready", 64'(pu_ready), 0);
            step();
        end

        // R5: ports 3 and 7, single beats; pointer 0 -> 3 then 7
        pu_valid[3] = 1; pu_last[3] = 1;
        pu_valid[7] = 1; pu_last[7] = 1;
        chk_grant("R5", 3);
        chk("R8", "hu_last", 64'(hu_last), 1);
        step();
        pu_valid[3] = 0;
        chk_grant("R5", 7);
        step();
        pu_valid[7] = 0; pu_last = '0;

        // R6: pointer 8; port 9 three beats with a stall, port 10 waits
        pu_valid[9] = 1; pu_valid[10] = 1; pu_last[10] = 1;
        chk_grant("R6", 9);
        chk("R8", "hu_last first", 64'(hu_last), 0);
        step();
        hu_ready = 1'b0;
        chk_grant("R6", 9);
        step();
        hu_ready = 1'b1; pu_last[9] = 1;
        chk_grant("R6", 9);
        step();
        pu_valid[9] = 0; pu_last[9] = 0;
        chk_grant("R6", 10);
        step();
        pu_valid[10] = 0; pu_last = '0;

        // R5 wrap: pointer 11; ports 1 and 12 -> 12 then 1
        pu_valid[1] = 1; pu_last[1] = 1; pu_valid[12] = 1; pu_last[12] = 1;
        chk_grant("R5", 12);
        step();
        pu_valid[12] = 0;
        chk_grant("R5", 1);
        step();
        pu_valid[1] = 0; pu_last = '0;

        // R4: pointer held at 2 across idle cycles
        for (int c = 0; c < 4; c++) step();
        pu_valid[0] = 1; pu_last[0] = 1; pu_valid[2] = 1; pu_last[2] = 1;
        chk_grant("R4", 2);
        step();
        pu_valid = '0; pu_last = '0;

        // R6: owner 6 drops valid mid-packet, port 8 must not be served
        pu_valid[6] = 1;
        chk_grant("R6", 6);
        step();
        pu_valid[6] = 0; pu_valid[8] = 1; pu_last[8] = 1;
        #1;
        chk("R6", "owner gap hu_valid", 64'(hu_valid), 0);
        chk("R7", "owner gap pu_ready", 64'(pu_ready), 64'(1) << 6);
        step();
        pu_valid[6] = 1; pu_last[6] = 1;
        chk_grant("R6", 6);
        step();
        pu_valid[6] = 0; pu_last[6] = 0;
        chk_grant("R5", 8);
        step();
        pu_valid = '0; pu_last = '0;

        // R9: all ports request, pointer 9, grants go 9,10,...,15,0,1,...
        pu_valid = '1; pu_last = '1;
        begin
            int wait2 = -1;
            for (int k = 0; k < 20; k++) begin
                #1;
                chk("R9", "rotation", 64'(hu_data), 64'(word_of((9 + k) % N)));
                if (wait2 < 0 && hu_data == word_of(2)) wait2 = k;
                step();
            end
            chk("R9", "port 2 served within N-1", 64'(wait2 >= 0 && wait2 <= N - 1), 1);
        end
        pu_valid = '0; pu_last = '0;

        // R5: reset during a held packet returns pointer to 0
        pu_valid[5] = 1;
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        pu_valid[4] = 1; pu_last[4] = 1;
        chk_grant("R5", 4);
        step();
        pu_valid = '0; pu_last = '0;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule